// File: doc/BRIEF.md
# Bang-Bang PID Loop Filter

This block is the digital loop filter of an all-digital PLL. It runs on a gated, divided copy of the oscillator clock. Each time the phase comparator produces a decision it asserts a valid strobe, and a single bit says whether the feedback edge was early or late. The filter turns these one-bit decisions into a 5-bit oscillator control word. The word is the running sum of the increments of a PID controller, so the proportional, integral and derivative actions all act through one accumulator. The gains are constant shifts that are fixed by parameters.

The accumulator is kept to 5 bits. When an update carries past the top of the range, the word wraps modulo 32 and a one-cycle overflow pulse goes to the downstream oscillator-control accumulator. When an update borrows below zero, the word also wraps and an underflow pulse goes out instead. In this way no tuning step is lost. The word is also presented split into an upper coarse field and a lower fine field, which feed separate tuning paths.

Top module: `pid_bb_filter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the word to mid-scale 5'b10000 (16), clears both stored past errors to 0, and drives ovf and unf low.
- R2: Each strobe takes the signed error e = +1 when early=1 and e = -1 when early=0.
- R3: On a clock edge with dec_vld=1, the bench computes s = word + e·2^KI_SH + d1·2^KP_SH + d2·2^KD_SH. Here d1 = e − e1 and d2 = d1 − (e1 − e2), where e1 and e2 are the errors of the previous two strobes. The new word is s mod 32.
- R4: On an edge with dec_vld=0, the word and the stored past errors are unchanged, ovf and unf are low, and early has no effect.
- R5: When s > 31, ovf is high for exactly the cycle in which the wrapped word appears.
- R6: When s < 0, unf is high for exactly the cycle in which the wrapped word appears.
- R7: ovf and unf are never high together, and each is high only for a single update.
- R8: The coarse output equals the upper COARSE_W bits of the word (bits 4..2 by default). The fine output equals the remaining lower bits (bits 1..0).
- R9: Past errors advance only on strobes: e2 takes the old e1, and e1 takes the current e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided, gated oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vld | input | 1 | One phase decision is present this cycle |
| early | input | 1 | 1 = feedback early (+1), 0 = late (−1) |
| ctrl_word | output | W | Accumulated control word |
| coarse | output | COARSE_W | Upper field of the word |
| fine | output | W−COARSE_W | Lower field of the word |
| ovf | output | 1 | One-cycle carry-out pulse |
| unf | output | 1 | One-cycle borrow-out pulse |

## Verification
The bench builds the filter with its defaults: W=5, COARSE_W=3, KP_SH=1, KI_SH=0, KD_SH=0. With these values all three terms contribute, and a single update moves the word by at most 9 codes, so every one of the 32 word values is reached in a short run. Long runs of early and late decisions drive the word through both wrap directions. A pseudo-random stream with random idle gaps covers every past-error history, as well as updates that straddle the wrap points.

// File: rtl/pid_bb_filter.sv
module pid_bb_filter #(
  parameter int W        = 5,
  parameter int COARSE_W = 3,
  parameter int KP_SH    = 1,
  parameter int KI_SH    = 0,
  parameter int KD_SH    = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dec_vld,
  input  logic                  early,
  output logic [W-1:0]          ctrl_word,
  output logic [COARSE_W-1:0]   coarse,
  output logic [W-COARSE_W-1:0] fine,
  output logic                  ovf,
  output logic                  unf
);
  localparam int SW = W + KP_SH + KI_SH + KD_SH + 5;
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam logic signed [SW-1:0] TOP = SW'((2 ** W) - 1);

  logic [W-1:0]           acc;
  logic signed [1:0]      e1, e2;
  logic signed [SW-1:0]   err, p1, p2, d1, d2, step, sum;

  assign err  = {{(SW-1){~early}}, 1'b1};
  assign p1   = SW'(e1);
  assign p2   = SW'(e2);
  assign d1   = err - p1;
  assign d2   = d1 - (p1 - p2);
  assign step = (err <<< KI_SH) + (d1 <<< KP_SH) + (d2 <<< KD_SH);
  assign sum  = $signed({{(SW-W){1'b0}}, acc}) + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= MID;
      e1  <= '0;
      e2  <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= dec_vld && (sum > TOP);
      unf <= dec_vld && sum[SW-1];
      if (dec_vld) begin
        acc <= sum[W-1:0];
        e1  <= err[1:0];
        e2  <= e1;
      end
    end
  end

  assign ctrl_word = acc;
  assign coarse    = acc[W-1 -: COARSE_W];
  assign fine      = acc[W-COARSE_W-1:0];
endmodule

// File: rtl/pid_bb_filter_chk.sv
module pid_bb_filter_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         dec_vld,
  input logic [W-1:0] ctrl_word,
  input logic         ovf,
  input logic         unf
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);

  AST_RESET_MID: assert property (@(posedge clk) $past(rst) |-> (ctrl_word == MID && !ovf && !unf)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !dec_vld |=> $stable(ctrl_word)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !dec_vld |=> (!ovf && !unf)); // R4
  AST_OVF_WRAPS: assert property (@(posedge clk) disable iff (rst) $rose(ovf) |-> (ctrl_word < $past(ctrl_word))); // R5
  AST_UNF_WRAPS: assert property (@(posedge clk) disable iff (rst) $rose(unf) |-> (ctrl_word > $past(ctrl_word))); // R6
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (rst) !(ovf && unf)); // R7
endmodule

bind pid_bb_filter pid_bb_filter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dec_vld(dec_vld),
  .ctrl_word(ctrl_word), .ovf(ovf), .unf(unf)
);

// File: tb/tb_pid_bb_filter.sv
module tb_pid_bb_filter;
  localparam int PERIOD = 10;
  localparam int W = 5, CW = 3, KP = 1, KI = 0, KD = 0;

  logic clk = 0, rst = 1, dec_vld = 0, early = 0;
  logic [W-1:0] ctrl_word;
  logic [CW-1:0] coarse;
  logic [W-CW-1:0] fine;
  logic ovf, unf;

  int tests = 0, fails = 0;
  int mw = 16, m1 = 0, m2 = 0;
  int novf = 0, nunf = 0;
  logic [15:0] lfsr = 16'hACE1;

  pid_bb_filter #(.W(W), .COARSE_W(CW), .KP_SH(KP), .KI_SH(KI), .KD_SH(KD)) dut (
    .clk(clk), .rst(rst), .dec_vld(dec_vld), .early(early),
    .ctrl_word(ctrl_word), .coarse(coarse), .fine(fine), .ovf(ovf), .unf(unf));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(int eo, int eu);
    chk("R3 word", int'(ctrl_word), mw);
    chk("R5 ovf", int'(ovf), eo);
    chk("R6 unf", int'(unf), eu);
    chk("R8 coarse", int'(coarse), mw >> (W - CW));
    chk("R8 fine", int'(fine), mw % (1 << (W - CW)));
    if (ovf && unf) chk("R7 both", 1, 0);
  endtask

  // one cycle: v = strobe, er = early bit
  task automatic cyc(bit v, bit er);
    int e, d1, d2, s, eo, eu;
    dec_vld = v; early = er;
    eo = 0; eu = 0;
    if (v) begin
      e  = er ? 1 : -1;                 // R2
      d1 = e - m1;
      d2 = d1 - (m1 - m2);
      s  = mw + e * (1 << KI) + d1 * (1 << KP) + d2 * (1 << KD);
      eo = (s > 31) ? 1 : 0;
      eu = (s < 0) ? 1 : 0;
      mw = ((s % 32) + 32) % 32;
      m2 = m1; m1 = e;                  // R9
    end
    @(posedge clk); @(negedge clk);
    novf += int'(ovf); nunf += int'(unf);
    check_all(eo, eu);                  // R4 when v == 0
  endtask

  task automatic do_reset();
    rst = 1; dec_vld = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    mw = 16; m1 = 0; m2 = 0;
    chk("R1 word", int'(ctrl_word), 16);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 unf", int'(unf), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R5: run of early decisions carries past the top
    for (int i = 0; i < 24; i++) cyc(1, 1);
    // R4: idle cycles with toggling early bit
    for (int i = 0; i < 8; i++) cyc(0, i[0]);
    // R6: run of late decisions borrows below zero
    for (int i = 0; i < 48; i++) cyc(1, 0);
    // alternating pattern exercises derivative history
    for (int i = 0; i < 40; i++) cyc(1, i[0]);
    // R1 mid-run reset clears history
    do_reset();
    cyc(1, 0);
    // random stream with idle gaps
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[3:0] != 4'd0, lfsr[7]);
    end
    chk("R5 overflow seen", int'(novf > 0), 1);
    chk("R6 underflow seen", int'(nunf > 0), 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule